// File: doc/BRIEF.md
# SDA Stuck-Low Recovery Watchdog

This block guards the data line of an I2C target interface against a controller that stops clocking while the target is driving SDA low. A stalled controller cannot issue a START or a STOP, so the bus stays locked. The watchdog polls the synchronized SDA level at a fixed interval, which is 500 ms in the real system. It also keeps a count of completed single-byte target transactions. If SDA is low at a poll and that count has not moved since the last low poll, the bus is declared hung. The block then emits a one-cycle reset pulse to the target engine, which releases SDA.

While the host side is powered down, SDA is legitimately held low, and no recovery is triggered. In that state the saved snapshot of the activity count is moved away from the live count, so a poll just after wake-up cannot match by accident. Each recovery increments a wrapping recovery counter that software can read. The pulse also clears the activity count and restarts the poll schedule.

Top module: `sda_hang_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `tgt_rst_o` is 0 and `recov_cnt_o` is 0.
- R2: `sda_pin_i` passes through two synchronizer flops. While `en_i` is high, a poll occurs on every POLL_CYCLES-th rising edge, counted from the first edge at which `en_i` is high. A recovery decided at a poll shows up on `tgt_rst_o` in the cycle right after that poll edge.
- R3: A poll with `host_on_i`=1, synchronized SDA low, and a snapshot equal to the activity count raises `tgt_rst_o` for exactly one cycle.
- R4: The snapshot is all ones after reset and after every recovery. A low, non-matching poll with the host on copies the activity count into the snapshot. A poll that sees SDA high leaves the snapshot unchanged, so a low-high-low pattern with no activity still recovers at the third poll.
- R5: The activity count advances only on a `txn_done_i` strobe with `txn_single_i`=1, which marks a transaction of exactly one byte. A strobe with `txn_single_i`=0 has no effect on it.
- R6: A poll with `host_on_i`=0 never recovers. If the snapshot equals the activity count at such a poll, the snapshot is decremented by one.
- R7: A recovery pulse clears the activity count and restarts the poll schedule. The next poll comes POLL_CYCLES edges after the edge at which the pulse is seen, so back-to-back recoveries are 2*POLL_CYCLES+1 edges apart.
- R8: `recov_cnt_o` increments by one with each pulse, changes at no other time, and wraps modulo 2^CNT_W.
- R9: While `en_i` is low, no poll occurs and no recovery is raised.
- R10: SDA dropping after a quiet interval, then held low with no activity and the host on, produces the pulse at the second poll whose synchronized sample is low. This is always between POLL_CYCLES and 2*POLL_CYCLES+3 edges after the drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Watchdog enable; low holds the poll schedule at its start |
| sda_pin_i | input | 1 | Asynchronous SDA pin level |
| host_on_i | input | 1 | 1 when the host side is powered on |
| txn_done_i | input | 1 | One-cycle strobe at the end of a target transaction |
| txn_single_i | input | 1 | Qualifies `txn_done_i`: 1 when the transaction carried exactly one byte |
| tgt_rst_o | output | 1 | One-cycle recovery reset to the target engine |
| recov_cnt_o | output | CNT_W | Wrapping count of recoveries |

## Verification
The assertions assume that `txn_done_i` is a one-cycle strobe and that `host_on_i` and `en_i` change only between edges, not as glitches that coincide with a poll. The bench drives every input at the falling edge and changes `host_on_i`, `en_i` and SDA only mid-interval, well away from the poll edges. The single exception is a sweep of the SDA drop point across two whole poll intervals, which covers the synchronizer latency at every phase. In that sweep the expected pulse edge is computed from the two-flop delay and the poll spacing.

// File: rtl/sda_hang_guard_pkg.sv
`timescale 1ns/1ps
package sda_hang_guard_pkg;
  // Outcome of one poll of the SDA line
  typedef enum logic [1:0] {
    POLL_IDLE    = 2'd0,  // nothing to do
    POLL_TRACK   = 2'd1,  // SDA low, activity seen: refresh snapshot
    POLL_RECOVER = 2'd2,  // SDA low, no activity: reset target
    POLL_BACKOFF = 2'd3   // host off, snapshot matches: nudge it away
  } poll_act_e;
endpackage

// File: rtl/sda_hang_sync.sv
`timescale 1ns/1ps
module sda_hang_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sda_hang_ticker.sv
`timescale 1ns/1ps
module sda_hang_ticker #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int             CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0]  LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) cnt <= '0;
    else if (cnt == LAST)           cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign tick_o = run_i && !restart_i && (cnt == LAST);
endmodule

// File: rtl/sda_hang_activity.sv
`timescale 1ns/1ps
module sda_hang_activity #(
  parameter int ACT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             done_i,
  input  logic             single_i,
  output logic [ACT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i)        count_o <= '0;
    else if (done_i && single_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/sda_hang_judge.sv
`timescale 1ns/1ps
module sda_hang_judge
  import sda_hang_guard_pkg::*;
#(
  parameter int ACT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             poll_i,
  input  logic             host_on_i,
  input  logic             sda_low_i,
  input  logic [ACT_W-1:0] act_i,
  output poll_act_e        act_o
);
  localparam logic [ACT_W-1:0] SNAP_INIT = '1;

  logic [ACT_W-1:0] snap;
  logic             same;

  assign same = (snap == act_i);

  always_comb begin
    act_o = POLL_IDLE;
    if (poll_i) begin
      if (host_on_i) begin
        if (sda_low_i) act_o = same ? POLL_RECOVER : POLL_TRACK;
      end else if (same) begin
        act_o = POLL_BACKOFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= SNAP_INIT;
    end else begin
      unique case (act_o)
        POLL_TRACK:   snap <= act_i;
        POLL_RECOVER: snap <= SNAP_INIT;
        POLL_BACKOFF: snap <= snap - 1'b1;
        default:      snap <= snap;
      endcase
    end
  end
endmodule

// File: rtl/sda_hang_guard.sv
`timescale 1ns/1ps
module sda_hang_guard
  import sda_hang_guard_pkg::*;
#(
  parameter int POLL_CYCLES = 50_000_000,
  parameter int ACT_W       = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             sda_pin_i,
  input  logic             host_on_i,
  input  logic             txn_done_i,
  input  logic             txn_single_i,
  output logic             tgt_rst_o,
  output logic [CNT_W-1:0] recov_cnt_o
);
  logic             sda_sync;
  logic             poll_tick;
  logic [ACT_W-1:0] act_cnt;
  poll_act_e        decision;

  sda_hang_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sda_pin_i),
    .q_o (sda_sync)
  );

  sda_hang_ticker #(.PERIOD(POLL_CYCLES)) u_ticker (
    .clk       (clk),
    .rst       (rst),
    .run_i     (en_i),
    .restart_i (tgt_rst_o),
    .tick_o    (poll_tick)
  );

  sda_hang_activity #(.ACT_W(ACT_W)) u_activity (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (tgt_rst_o),
    .done_i   (txn_done_i),
    .single_i (txn_single_i),
    .count_o  (act_cnt)
  );

  sda_hang_judge #(.ACT_W(ACT_W)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .poll_i    (poll_tick),
    .host_on_i (host_on_i),
    .sda_low_i (!sda_sync),
    .act_i     (act_cnt),
    .act_o     (decision)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_rst_o   <= 1'b0;
      recov_cnt_o <= '0;
    end else begin
      tgt_rst_o <= (decision == POLL_RECOVER);
      if (decision == POLL_RECOVER) recov_cnt_o <= recov_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/sda_hang_guard_chk.sv
`timescale 1ns/1ps
module sda_hang_guard_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             host_on_i,
  input logic             sda_sync,
  input logic             poll_tick,
  input logic             tgt_rst_o,
  input logic [CNT_W-1:0] recov_cnt_o
);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_o |=> !tgt_rst_o);

  assert_pulse_from_low_poll_R3: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_o |-> ($past(poll_tick) && !$past(sda_sync)));

  assert_host_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_o |-> $past(host_on_i));

  assert_no_poll_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> !poll_tick);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_o |-> (recov_cnt_o == CNT_W'($past(recov_cnt_o) + 1'b1)));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_o |-> $stable(recov_cnt_o));

  assert_schedule_restart_R7: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_o |=> !poll_tick);
endmodule

bind sda_hang_guard sda_hang_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .host_on_i   (host_on_i),
  .sda_sync    (sda_sync),
  .poll_tick   (poll_tick),
  .tgt_rst_o   (tgt_rst_o),
  .recov_cnt_o (recov_cnt_o)
);

// File: tb/sda_hang_guard_bench.sv
`timescale 1ns/1ps
module sda_hang_guard_bench;
  localparam int P     = 16;
  localparam int CNT_W = 4;
  localparam int ACT_W = 8;

  logic             clk = 1'b0;
  logic             rst, en, sda, host, done, single;
  logic             pulse;
  logic [CNT_W-1:0] cnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sda_hang_guard #(.POLL_CYCLES(P), .ACT_W(ACT_W), .CNT_W(CNT_W)) u_sda_hang_guard (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en),
    .sda_pin_i    (sda),
    .host_on_i    (host),
    .txn_done_i   (done),
    .txn_single_i (single),
    .tgt_rst_o    (pulse),
    .recov_cnt_o  (cnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; sda = 1'b1; host = 1'b1; done = 1'b0; single = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // runs n edges, returns how many pulses were observed
  task automatic run_edges(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (pulse) pulses++;
    end
  endtask

  // edges until the pulse is seen, -1 on timeout
  task automatic wait_pulse(input int max, output int n);
    n = -1;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk); @(negedge clk);
      if (pulse) begin n = i; break; end
    end
  endtask

  // SDA low and synchronized before enabling
  task automatic start_low();
    int pc;
    sda = 1'b0;
    run_edges(3, pc);
    en = 1'b1;
  endtask

  initial begin
    int n, pc, consumed, k1, exp_n;
    do_reset();
    // R1: reset state
    check(pulse == 1'b0, "R1", "pulse after reset", pulse, 0);
    check(cnt == '0, "R1", "count after reset", cnt, 0);

    // R2 R3 R4: stuck from the start recovers at the second poll
    start_low();
    wait_pulse(10*P, n);
    check(n == 2*P, "R2", "edges to first recovery", n, 2*P);
    check(cnt == 1, "R8", "count after first recovery", cnt, 1);
    @(posedge clk); @(negedge clk);
    check(pulse == 1'b0, "R3", "pulse width one cycle", pulse, 0);
    // R7: restart spacing 2P+1 (one edge already used)
    wait_pulse(10*P, n);
    check(n == 2*P, "R7", "edges between recoveries minus one", n, 2*P);
    check(cnt == 2, "R8", "count after second recovery", cnt, 2);

    // R5: single-byte transaction delays recovery by one poll
    do_reset(); start_low();
    run_edges(P + P/2, pc);
    check(pc == 0, "R5", "pulses before strobe", pc, 0);
    done = 1'b1; single = 1'b1;
    @(posedge clk); @(negedge clk);
    done = 1'b0; single = 1'b0;
    consumed = P + P/2 + 1;
    wait_pulse(10*P, n);
    check(n == 3*P - consumed, "R5", "single-byte activity delays recovery", n, 3*P - consumed);

    // R5: multi-byte transaction ignored
    do_reset(); start_low();
    run_edges(P + P/2, pc);
    done = 1'b1; single = 1'b0;
    @(posedge clk); @(negedge clk);
    done = 1'b0;
    wait_pulse(10*P, n);
    check(n == 2*P - consumed, "R5", "multi-byte activity ignored", n, 2*P - consumed);

    // R6: host off never recovers
    do_reset(); host = 1'b0; start_low();
    run_edges(6*P, pc);
    check(pc == 0, "R6", "pulses while host off", pc, 0);
    check(cnt == 0, "R6", "count while host off", cnt, 0);

    // R6: snapshot backoff prevents false match after wake
    do_reset(); start_low();
    run_edges(P + P/2, pc);
    host = 1'b0;
    run_edges(2*P, pc);
    check(pc == 0, "R6", "pulses during host-off span", pc, 0);
    host = 1'b1;
    wait_pulse(10*P, n);
    check(n == 5*P - (3*P + P/2), "R6", "recovery after wake", n, 5*P - (3*P + P/2));

    // R4: low-high-low with no activity recovers at the third poll
    do_reset(); start_low();
    run_edges(P + P/2, pc);
    sda = 1'b1;
    run_edges(P, pc);
    sda = 1'b0;
    wait_pulse(10*P, n);
    check(n == 3*P - (2*P + P/2), "R4", "high poll keeps snapshot", n, 3*P - (2*P + P/2));

    // R9: disabled watchdog is silent, then starts a fresh schedule
    do_reset(); sda = 1'b0;
    run_edges(6*P, pc);
    check(pc == 0, "R9", "pulses while disabled", pc, 0);
    en = 1'b1;
    wait_pulse(10*P, n);
    check(n == 2*P, "R9", "edges to recovery after enable", n, 2*P);

    // R8: count wraps modulo 2^CNT_W
    do_reset(); start_low();
    for (int k = 1; k <= (1 << CNT_W) + 1; k++) begin
      wait_pulse(10*P, n);
      check(cnt == CNT_W'(k), "R8", "wrapping recovery count", cnt, k % (1 << CNT_W));
    end

    // R10: sweep the drop point across two poll intervals
    for (int d = P; d < 3*P; d++) begin
      do_reset(); en = 1'b1;
      run_edges(d, pc);
      sda = 1'b0;
      k1 = ((d + 3 + P - 1) / P) * P;
      exp_n = k1 + P - d;
      wait_pulse(10*P, n);
      check(n == exp_n, "R10", "latency after SDA drop", n, exp_n);
      check(n >= P && n <= 2*P + 3, "R10", "latency within bound", n, 2*P);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule